// File: doc/BRIEF.md
# Accumulator Word Store Unit

This unit turns a wide signed accumulator into a single 16-bit word and issues the matching write. It sits after the multiply-accumulate datapath. A store request presents the accumulator, a signed shift amount, a rounding choice, a saturation choice, an addressing mode and the current pointer. One clock later the unit drives the word to write, the target address, a memory or register write strobe, and the pointer value to write back.

The word is formed in three steps. The accumulator is first shifted by a signed 4-bit amount. It is then optionally rounded at the word boundary, using either the conventional rule or the round-half-to-even rule. Finally, bits 31:16 are clamped to the signed 16-bit range when write saturation is on. The addressing mode decides four things: whether the word goes to a register or to memory, which address is used, whether the pointer moves by 2, and whether it moves before or after the write.

Top module: `acs_store`

## Requirements
- R1: A request sampled at a rising clock edge appears on the outputs after that edge. With no request, all three strobes are 0 after the next edge and `wr_data_o` keeps its value.
- R2: With rounding off, the stored word is bits 31:16 of the shifted, sign-extended accumulator, and the lower 16 bits are dropped.
- R3: `shift_i` is a two's-complement 4-bit count. A positive value (1 to 7) shifts right arithmetically. A negative value (-1 to -8, codes 0xF to 0x8) shifts left by its magnitude.
- R4: With `round_i`=1 and `conv_i`=1, the unit adds 1 at bit 16 whenever bit 15 of the shifted value is 1.
- R5: With `round_i`=1 and `conv_i`=0, the rule is the same, except that when bits 15:0 are exactly 0x8000 the unit adds 1 only if bit 16 is 1, so that the word is even.
- R6: With `sat_i`=1, a rounded value outside -32768..32767 is written as 0x7FFF (positive) or 0x8000 (negative). With `sat_i`=0, bits 31:16 are written unchanged.
- R7: Mode 0 is the register target. It raises `reg_we_o` only, `wr_addr_o` carries `ptr_i`, and the pointer is not written.
- R8: Mode 1 is plain indirect. It raises `mem_we_o` at address `ptr_i` and does not write the pointer.
- R9: Modes 2 and 3 (post-increment, post-decrement) write at `ptr_i` and return `ptr_i`+2 or `ptr_i`-2 with `ptr_we_o`=1.
- R10: Modes 4 and 5 (pre-increment, pre-decrement) write at `ptr_i`+2 or `ptr_i`-2 and return that same value with `ptr_we_o`=1. All pointer arithmetic wraps modulo 2^16.
- R11: Mode codes 6 and 7 raise no strobe, and `wr_addr_o` and `ptr_o` both carry `ptr_i`.
- R12: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Store request |
| acc_i | input | 40 | Accumulator value, signed |
| shift_i | input | 4 | Signed shift count, positive means right |
| round_i | input | 1 | 1 = round, 0 = truncate |
| conv_i | input | 1 | 1 = conventional rounding, 0 = round-half-to-even |
| sat_i | input | 1 | Write saturation enable |
| mode_i | input | 3 | Addressing mode code |
| ptr_i | input | 16 | Current pointer |
| wr_data_o | output | 16 | Word to write |
| wr_addr_o | output | 16 | Write address (register index in mode 0) |
| mem_we_o | output | 1 | Memory write strobe |
| reg_we_o | output | 1 | Register write strobe |
| ptr_o | output | 16 | Updated pointer |
| ptr_we_o | output | 1 | Pointer write-back strobe |

## Verification
Rounding and saturation can act on the same word. The rounding carry from a value just below the positive limit, such as 0x7FFF_8000, pushes the result to 0x8000. With saturation off, the bench expects that wrapped value. With saturation on, it expects 0x7FFF. A left shift that overflows the word is judged in the same way under saturation. Pointer update and data write also happen in the same cycle: for every pre- and post-modifying mode, including wrap at both ends of the address space, the bench compares the address and the returned pointer from a single request.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int ACC_W   = 40;
  localparam int DATA_W  = 16;
  localparam int FRAC_W  = 16;
  localparam int SHIFT_W = 4;
  localparam int PTR_W   = 16;
  localparam int STEP    = 2;

  typedef enum logic [2:0] {
    AM_REG     = 3'd0,
    AM_IND     = 3'd1,
    AM_POSTINC = 3'd2,
    AM_POSTDEC = 3'd3,
    AM_PREINC  = 3'd4,
    AM_PREDEC  = 3'd5
  } addr_mode_e;
endpackage

// File: rtl/acs_shift.sv
module acs_shift #(
  parameter int ACC_W   = 40,
  parameter int SHIFT_W = 4,
  localparam int EXT_W  = ACC_W + (1 << (SHIFT_W - 1))
) (
  input  logic [ACC_W-1:0]   acc_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [EXT_W-1:0]   shifted_o
);
  logic signed [EXT_W-1:0] ext;
  logic [SHIFT_W-1:0]      mag;

  always_comb begin
    ext = signed'({{(EXT_W-ACC_W){acc_i[ACC_W-1]}}, acc_i});
    mag = (~shift_i) + 1'b1;
    if (shift_i[SHIFT_W-1]) begin
      shifted_o = ext << mag;
    end else begin
      shifted_o = ext >>> shift_i;
    end
  end
endmodule

// File: rtl/acs_round.sv
module acs_round #(
  parameter int IN_W   = 48,
  parameter int FRAC_W = 16,
  localparam int OUT_W = IN_W + 1
) (
  input  logic [IN_W-1:0]  val_i,
  input  logic             round_i,
  input  logic             conv_i,
  output logic [OUT_W-1:0] val_o
);
  localparam logic [FRAC_W-1:0] HALF = {1'b1, {(FRAC_W-1){1'b0}}};

  logic             tie;
  logic             bump;
  logic [OUT_W-1:0] wide;
  logic [OUT_W-1:0] inc;

  always_comb begin
    tie  = (val_i[FRAC_W-1:0] == HALF);
    bump = round_i & val_i[FRAC_W-1] & (conv_i | ~tie | val_i[FRAC_W]);
    wide = {val_i[IN_W-1], val_i};
    inc  = '0;
    inc[FRAC_W] = bump;
    val_o = wide + inc;
  end
endmodule

// File: rtl/acs_sat.sv
module acs_sat #(
  parameter int IN_W   = 49,
  parameter int FRAC_W = 16,
  parameter int DATA_W = 16,
  localparam int TOP   = FRAC_W + DATA_W - 1
) (
  input  logic [IN_W-1:0]   val_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] word_o
);
  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic [IN_W-1-TOP:0] upper;
  logic                fits;

  always_comb begin
    upper = val_i[IN_W-1:TOP];
    fits  = (&upper) | ~(|upper);
    if (sat_i && !fits) begin
      word_o = val_i[IN_W-1] ? NEG_LIM : POS_LIM;
    end else begin
      word_o = val_i[TOP:FRAC_W];
    end
  end
endmodule

// File: rtl/acs_addr.sv
module acs_addr
  import acs_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int STEP  = 2
) (
  input  logic [2:0]       mode_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [PTR_W-1:0] addr_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             mem_we_o,
  output logic             reg_we_o,
  output logic             ptr_we_o
);
  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

  logic [PTR_W-1:0] up;
  logic [PTR_W-1:0] dn;

  always_comb begin
    up       = ptr_i + STEP_V;
    dn       = ptr_i - STEP_V;
    addr_o   = ptr_i;
    ptr_o    = ptr_i;
    mem_we_o = 1'b0;
    reg_we_o = 1'b0;
    ptr_we_o = 1'b0;
    case (mode_i)
      AM_REG:     reg_we_o = 1'b1;
      AM_IND:     mem_we_o = 1'b1;
      AM_POSTINC: begin mem_we_o = 1'b1; ptr_o = up; ptr_we_o = 1'b1; end
      AM_POSTDEC: begin mem_we_o = 1'b1; ptr_o = dn; ptr_we_o = 1'b1; end
      AM_PREINC:  begin mem_we_o = 1'b1; ptr_o = up; addr_o = up; ptr_we_o = 1'b1; end
      AM_PREDEC:  begin mem_we_o = 1'b1; ptr_o = dn; addr_o = dn; ptr_we_o = 1'b1; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/acs_store.sv
module acs_store
  import acs_pkg::*;
#(
  parameter int P_ACC_W   = ACC_W,
  parameter int P_DATA_W  = DATA_W,
  parameter int P_FRAC_W  = FRAC_W,
  parameter int P_SHIFT_W = SHIFT_W,
  parameter int P_PTR_W   = PTR_W,
  parameter int P_STEP    = STEP
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic [P_ACC_W-1:0]    acc_i,
  input  logic [P_SHIFT_W-1:0]  shift_i,
  input  logic                  round_i,
  input  logic                  conv_i,
  input  logic                  sat_i,
  input  logic [2:0]            mode_i,
  input  logic [P_PTR_W-1:0]    ptr_i,
  output logic [P_DATA_W-1:0]   wr_data_o,
  output logic [P_PTR_W-1:0]    wr_addr_o,
  output logic                  mem_we_o,
  output logic                  reg_we_o,
  output logic [P_PTR_W-1:0]    ptr_o,
  output logic                  ptr_we_o
);
  localparam int EXT_W = P_ACC_W + (1 << (P_SHIFT_W - 1));
  localparam int RND_W = EXT_W + 1;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1] & rst_n;

  logic [EXT_W-1:0]    shifted;
  logic [RND_W-1:0]    rounded;
  logic [P_DATA_W-1:0] word;
  logic [P_PTR_W-1:0]  addr_c, ptr_c;
  logic                mem_we_c, reg_we_c, ptr_we_c;

  acs_shift #(.ACC_W(P_ACC_W), .SHIFT_W(P_SHIFT_W)) u_shift (
    .acc_i(acc_i), .shift_i(shift_i), .shifted_o(shifted)
  );

  acs_round #(.IN_W(EXT_W), .FRAC_W(P_FRAC_W)) u_round (
    .val_i(shifted), .round_i(round_i), .conv_i(conv_i), .val_o(rounded)
  );

  acs_sat #(.IN_W(RND_W), .FRAC_W(P_FRAC_W), .DATA_W(P_DATA_W)) u_sat (
    .val_i(rounded), .sat_i(sat_i), .word_o(word)
  );

  acs_addr #(.PTR_W(P_PTR_W), .STEP(P_STEP)) u_addr (
    .mode_i(mode_i), .ptr_i(ptr_i), .addr_o(addr_c), .ptr_o(ptr_c),
    .mem_we_o(mem_we_c), .reg_we_o(reg_we_c), .ptr_we_o(ptr_we_c)
  );

  logic [P_DATA_W-1:0] data_d;
  logic [P_PTR_W-1:0]  addr_d, ptr_d;
  logic                mem_we_d, reg_we_d, ptr_we_d;

  always_comb begin
    data_d   = wr_data_o;
    addr_d   = wr_addr_o;
    ptr_d    = ptr_o;
    mem_we_d = 1'b0;
    reg_we_d = 1'b0;
    ptr_we_d = 1'b0;
    if (req_i) begin
      data_d   = word;
      addr_d   = addr_c;
      ptr_d    = ptr_c;
      mem_we_d = mem_we_c;
      reg_we_d = reg_we_c;
      ptr_we_d = ptr_we_c;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_data_o <= '0;
      wr_addr_o <= '0;
      ptr_o     <= '0;
      mem_we_o  <= 1'b0;
      reg_we_o  <= 1'b0;
      ptr_we_o  <= 1'b0;
    end else begin
      wr_data_o <= data_d;
      wr_addr_o <= addr_d;
      ptr_o     <= ptr_d;
      mem_we_o  <= mem_we_d;
      reg_we_o  <= reg_we_d;
      ptr_we_o  <= ptr_we_d;
    end
  end
endmodule

// File: rtl/acs_store_chk.sv
module acs_store_chk #(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 16,
  parameter int STEP   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic [2:0]        mode_i,
  input logic [PTR_W-1:0]  ptr_i,
  input logic [DATA_W-1:0] wr_data_o,
  input logic [PTR_W-1:0]  wr_addr_o,
  input logic              mem_we_o,
  input logic              reg_we_o,
  input logic [PTR_W-1:0]  ptr_o,
  input logic              ptr_we_o
);
  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

  p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!mem_we_o && !reg_we_o && !ptr_we_o));

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(wr_data_o));

  p_single_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we_o, reg_we_o}));

  p_reg_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 3'd0) |=> (reg_we_o && !ptr_we_o && wr_addr_o == $past(ptr_i)));

  p_indirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 3'd1) |=> (mem_we_o && !ptr_we_o && wr_addr_o == $past(ptr_i)));

  p_post_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 3'd2) |=> (wr_addr_o == $past(ptr_i) && ptr_o == wr_addr_o + STEP_V));

  p_pre_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 3'd5) |=> (ptr_o == wr_addr_o && wr_addr_o == $past(ptr_i) - STEP_V));

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i[2:1] == 2'b11) |=> (!mem_we_o && !reg_we_o && !ptr_we_o));
endmodule

bind acs_store acs_store_chk #(.PTR_W(P_PTR_W), .DATA_W(P_DATA_W), .STEP(P_STEP)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_i(req_i), .mode_i(mode_i), .ptr_i(ptr_i),
  .wr_data_o(wr_data_o), .wr_addr_o(wr_addr_o), .mem_we_o(mem_we_o),
  .reg_we_o(reg_we_o), .ptr_o(ptr_o), .ptr_we_o(ptr_we_o)
);

// File: tb/test_acs_store.sv
module test_acs_store;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [39:0] acc;
  logic [3:0]  sh;
  logic        rnd, conv, sat;
  logic [2:0]  mode;
  logic [15:0] ptr;
  logic [15:0] wdata, waddr, nptr;
  logic        mwe, rwe, pwe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  acs_store i_acs_store (
    .clk(clk), .rst_n(rst_n), .req_i(req), .acc_i(acc), .shift_i(sh),
    .round_i(rnd), .conv_i(conv), .sat_i(sat), .mode_i(mode), .ptr_i(ptr),
    .wr_data_o(wdata), .wr_addr_o(waddr), .mem_we_o(mwe), .reg_we_o(rwe),
    .ptr_o(nptr), .ptr_we_o(pwe)
  );

  typedef struct packed {
    logic [7:0]  rq;
    logic [39:0] acc;
    logic [3:0]  sh;
    logic        rnd, conv, sat;
    logic [2:0]  mode;
    logic [15:0] ptr;
    logic [15:0] data, addr, nptr;
    logic        mwe, rwe, pwe;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{8'd2,  40'h00_1234_5678, 4'h0, 1'b0,1'b0,1'b0, 3'd1, 16'h0100, 16'h1234, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R2
    '{8'd2,  40'h00_1234_8000, 4'h0, 1'b0,1'b0,1'b0, 3'd1, 16'h0100, 16'h1234, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R2
    '{8'd4,  40'h00_1234_8000, 4'h0, 1'b1,1'b1,1'b0, 3'd1, 16'h0100, 16'h1235, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R4
    '{8'd5,  40'h00_1234_8000, 4'h0, 1'b1,1'b0,1'b0, 3'd1, 16'h0100, 16'h1234, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R5
    '{8'd5,  40'h00_1235_8000, 4'h0, 1'b1,1'b0,1'b0, 3'd1, 16'h0100, 16'h1236, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R5
    '{8'd5,  40'h00_1234_8001, 4'h0, 1'b1,1'b0,1'b0, 3'd1, 16'h0100, 16'h1235, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R5
    '{8'd5,  40'h00_1234_7FFF, 4'h0, 1'b1,1'b0,1'b0, 3'd1, 16'h0100, 16'h1234, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R5
    '{8'd4,  40'hFF_FFFE_8000, 4'h0, 1'b1,1'b1,1'b0, 3'd1, 16'h0100, 16'hFFFF, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R4
    '{8'd5,  40'hFF_FFFE_8000, 4'h0, 1'b1,1'b0,1'b0, 3'd1, 16'h0100, 16'hFFFE, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R5
    '{8'd3,  40'h00_1234_0000, 4'h4, 1'b0,1'b0,1'b0, 3'd1, 16'h0100, 16'h0123, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R3
    '{8'd3,  40'h00_0123_4000, 4'hC, 1'b0,1'b0,1'b0, 3'd1, 16'h0100, 16'h1234, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R3
    '{8'd3,  40'h00_0012_3456, 4'h8, 1'b0,1'b0,1'b0, 3'd1, 16'h0100, 16'h1234, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R3
    '{8'd3,  40'hFF_8000_0000, 4'h4, 1'b0,1'b0,1'b0, 3'd1, 16'h0100, 16'hF800, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R3
    '{8'd3,  40'h00_8000_0000, 4'h7, 1'b0,1'b0,1'b0, 3'd1, 16'h0100, 16'h0100, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R3
    '{8'd6,  40'h00_8000_0000, 4'h0, 1'b0,1'b0,1'b1, 3'd1, 16'h0100, 16'h7FFF, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R6
    '{8'd6,  40'h00_8000_0000, 4'h0, 1'b0,1'b0,1'b0, 3'd1, 16'h0100, 16'h8000, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R6
    '{8'd6,  40'hFF_7FFF_0000, 4'h0, 1'b0,1'b0,1'b1, 3'd1, 16'h0100, 16'h8000, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R6
    '{8'd6,  40'hFF_7FFF_0000, 4'h0, 1'b0,1'b0,1'b0, 3'd1, 16'h0100, 16'h7FFF, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R6
    '{8'd6,  40'hFF_8000_0000, 4'h0, 1'b0,1'b0,1'b1, 3'd1, 16'h0100, 16'h8000, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R6
    '{8'd6,  40'h00_7FFF_8000, 4'h0, 1'b1,1'b1,1'b1, 3'd1, 16'h0100, 16'h7FFF, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R6 with R4 carry
    '{8'd4,  40'h00_7FFF_8000, 4'h0, 1'b1,1'b1,1'b0, 3'd1, 16'h0100, 16'h8000, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R4
    '{8'd6,  40'h00_0800_0000, 4'hC, 1'b0,1'b0,1'b1, 3'd1, 16'h0100, 16'h7FFF, 16'h0100, 16'h0100, 1'b1,1'b0,1'b0}, // R6 with R3
    '{8'd7,  40'h00_1234_5678, 4'h0, 1'b0,1'b0,1'b0, 3'd0, 16'h0007, 16'h1234, 16'h0007, 16'h0007, 1'b0,1'b1,1'b0}, // R7
    '{8'd9,  40'h00_1234_5678, 4'h0, 1'b0,1'b0,1'b0, 3'd2, 16'h0100, 16'h1234, 16'h0100, 16'h0102, 1'b1,1'b0,1'b1}, // R9
    '{8'd9,  40'h00_1234_5678, 4'h0, 1'b0,1'b0,1'b0, 3'd3, 16'h0100, 16'h1234, 16'h0100, 16'h00FE, 1'b1,1'b0,1'b1}, // R9
    '{8'd10, 40'h00_1234_5678, 4'h0, 1'b0,1'b0,1'b0, 3'd4, 16'h0100, 16'h1234, 16'h0102, 16'h0102, 1'b1,1'b0,1'b1}, // R10
    '{8'd10, 40'h00_1234_5678, 4'h0, 1'b0,1'b0,1'b0, 3'd5, 16'h0100, 16'h1234, 16'h00FE, 16'h00FE, 1'b1,1'b0,1'b1}, // R10
    '{8'd10, 40'h00_1234_5678, 4'h0, 1'b0,1'b0,1'b0, 3'd4, 16'hFFFE, 16'h1234, 16'h0000, 16'h0000, 1'b1,1'b0,1'b1}, // R10 wrap
    '{8'd9,  40'h00_1234_5678, 4'h0, 1'b0,1'b0,1'b0, 3'd3, 16'h0000, 16'h1234, 16'h0000, 16'hFFFE, 1'b1,1'b0,1'b1}, // R9 wrap
    '{8'd11, 40'h00_1234_5678, 4'h0, 1'b0,1'b0,1'b0, 3'd6, 16'h0100, 16'h1234, 16'h0100, 16'h0100, 1'b0,1'b0,1'b0}, // R11
    '{8'd11, 40'h00_1234_5678, 4'h0, 1'b0,1'b0,1'b0, 3'd7, 16'h0100, 16'h1234, 16'h0100, 16'h0100, 1'b0,1'b0,1'b0}  // R11
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    acc = v.acc; sh = v.sh; rnd = v.rnd; conv = v.conv; sat = v.sat;
    mode = v.mode; ptr = v.ptr; req = 1'b1;
  endtask

  task automatic check_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.rq);
    check({tag, " data"}, wdata, v.data);
    check({tag, " addr"}, waddr, v.addr);
    check({tag, " ptr"}, nptr, v.nptr);
    check({tag, " strobes"}, {13'd0, mwe, rwe, pwe}, {13'd0, v.mwe, v.rwe, v.pwe});
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; acc = '0; sh = '0; rnd = 1'b0; conv = 1'b0;
    sat = 1'b0; mode = 3'd1; ptr = '0;
    repeat (3) @(negedge clk);
    // R12: reset state of every output
    check("R12 data", wdata, 16'h0);
    check("R12 addr", waddr, 16'h0);
    check("R12 ptr", nptr, 16'h0);
    check("R12 strobes", {13'd0, mwe, rwe, pwe}, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      req = 1'b0;
      check_vec(VEC[i]);
      @(negedge clk);
    end

    // R1: back-to-back requests, each visible one edge later
    drive(VEC[23]);
    @(negedge clk);
    check_vec(VEC[23]);
    drive(VEC[26]);
    @(negedge clk);
    check_vec(VEC[26]);
    req = 1'b0;
    acc = 40'h00_5555_0000;
    @(negedge clk);
    // R1: idle drops strobes and holds the last word
    check("R1 idle strobes", {13'd0, mwe, rwe, pwe}, 16'h0);
    check("R1 idle data hold", wdata, 16'h1234);
    @(negedge clk);
    check("R1 idle data hold 2", wdata, 16'h1234);

    // R12: reset in mid-run clears outputs at once
    drive(VEC[23]);
    @(negedge clk);
    req = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    check("R12 async data", wdata, 16'h0);
    check("R12 async ptr", nptr, 16'h0);
    check("R12 async strobes", {13'd0, mwe, rwe, pwe}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule